// File: doc/BRIEF.md
# Change-of-State Event Sense Bank

This block watches sixty-four digital inputs, grouped as eight ports of eight channels. Each channel has a detector that can be armed for rising or falling transitions. When an armed channel sees its chosen edge, the block latches an event flag. An active-low interrupt line goes low while any flag is latched and the interrupt enable is on. Inputs pass through a two-stage synchronizer before edge detection.

Software reaches the block through a small synchronous register port, with byte addresses, write data and registered read data. A two-bit bank field selects what the port addresses show. In the level bank, a port address reads back the live input levels. In the event bank, it reads back the latched flags and accepts arm/clear writes. The same control address also holds a per-port write mask, and its low bits mean different things in each bank. Edge polarity is set per group of four channels through write-only registers, so software keeps its own copy.

To detect a change of state on one signal, wire it to two channels with opposite polarity. Either channel's flag then raises the interrupt.

Top module: `cos_event_bank`

## Requirements
- R1: After reset all flags, arm bits, mask bits, polarity bits and the interrupt enable are 0, bank 0 is selected, the control register (0xA) reads 0x00, and irq_no is high.
- R2: A write to address 0xA sets the bank from wdata bits 7:6 in any bank, and a read of 0xA returns the bank in bits 7:6. Bank 0 is the level bank and bank 1 is the event bank. In banks 2 and 3, port addresses read 0.
- R3: In bank 0, a read of port address n (0x0–0x7) returns the input levels of port n as seen through the two-flop synchronizer. Bit i is channel 8n+i.
- R4: In bank 1, a read of port address n returns the eight latched event flags of port n.
- R5: Address 0x8 sets polarity for ports 0–3 and address 0x9 for ports 4–7. Within each byte, bit 2k covers channels 0–3 of the k-th port and bit 2k+1 covers channels 4–7. A polarity bit of 0 means rising edges and 1 means falling edges. For example, writing 0x02 to 0x8 makes port 0 channels 0–3 rising-sensitive and channels 4–7 falling-sensitive.
- R6: The polarity registers are write-only. A read of 0x8 or 0x9 returns 0x00.
- R7: In bank 1, a write to port address n updates each channel of port n by its data bit. A 1 arms the detector. A 0 clears the latched flag and disarms the detector. A clear takes precedence over an edge in the same cycle.
- R8: A flag sets only on the selected edge of an armed channel and then holds until a 0 is written to it. Writing 1 to a channel whose flag is set leaves the flag set.
- R9: Writes to 0xA also load the write mask of the bank selected before the write. In bank 0, bits 5:0 load the masks of ports 0–5. In bank 1, bits 1:0 load the masks of ports 7:6. A read of 0xA returns that bank's mask field in the same bits. A masked port ignores arm/clear writes.
- R10: irq_no is low exactly when bit 0 of the interrupt enable register (0xC, read back in bit 0) is 1 and at least one flag is set.
- R11: In bank 0, writes to port addresses have no effect on flags or arm bits.
- R12: One signal wired to two channels of opposite polarity latches the rising-sensitive channel's flag on its rise and the falling-sensitive channel's flag on its fall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe; rdata_o valid the next cycle |
| addr_i | input | 4 | Register byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| din_i | input | 64 | Asynchronous channel inputs, channel c on bit c |
| irq_no | output | 1 | Active-low level interrupt |

## Verification
The bench targets the places where the address-sharing scheme can go wrong.

- Port reads are compared in both banks after the same input changes. A design that mixed up the level and flag views, or applied the mask field of the wrong bank, returns the other byte.
- Polarity is driven with mixed nibble settings, and an input pattern is chosen that toggles both directions at once. A design that swapped the nibble bit order, or the rising/falling sense, flags the complementary nibble.
- Flags are checked after a 1 is rewritten over a latched flag, after a partial clear, and after a write to a masked port. A design that cleared on 1, re-armed on a masked write, or acted on bank 0 port writes shows flags appearing or vanishing.
- The interrupt line is checked with the enable off and with it on, across flags in separate ports.

// File: rtl/esb_pkg.sv
package esb_pkg;
  localparam int PORT_W    = 8;
  localparam int NUM_PORTS = 8;
  localparam int NUM_CH    = PORT_W * NUM_PORTS;
  localparam int ADDR_W    = 4;
  localparam int POL_W     = 2 * NUM_PORTS;
  localparam int MASK_LO_W = 6;
  localparam int MASK_HI_W = NUM_PORTS - MASK_LO_W;

  localparam logic [ADDR_W-1:0] ADDR_POL_LO = 4'h8;
  localparam logic [ADDR_W-1:0] ADDR_POL_HI = 4'h9;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 4'hA;
  localparam logic [ADDR_W-1:0] ADDR_IE     = 4'hC;

  typedef enum logic [1:0] {
    BANK_LEVEL = 2'd0,
    BANK_EVENT = 2'd1,
    BANK_RSV2  = 2'd2,
    BANK_RSV3  = 2'd3
  } bank_e;
endpackage

// File: rtl/esb_sync.sv
module esb_sync #(
  parameter int W      = 64,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/esb_port.sv
module esb_port #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic [1:0]   pol_i,   // [0] lower half, [1] upper half; 1 = falling
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] flag_o
);
  localparam int HALF = W / 2;

  logic [W-1:0] prev_q, arm_q, flag_q, hit;

  always_comb begin
    for (int i = 0; i < W; i++) begin
      hit[i] = pol_i[i / HALF] ? (prev_q[i] & ~lvl_i[i])
                               : (~prev_q[i] & lvl_i[i]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      arm_q  <= '0;
      flag_q <= '0;
    end else begin
      prev_q <= lvl_i;
      if (we_i) arm_q <= wdata_i;
      for (int i = 0; i < W; i++) begin
        if (we_i && !wdata_i[i])      flag_q[i] <= 1'b0;
        else if (arm_q[i] && hit[i])  flag_q[i] <= 1'b1;
      end
    end
  end

  assign flag_o = flag_q;

  p_clear_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ((flag_q & ~$past(wdata_i)) == '0));

  p_arm_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (arm_q == $past(wdata_i)));

  p_set_needs_arm_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q & ~$past(flag_q) & ~$past(arm_q)) == '0);

  p_flag_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> (($past(flag_q) & ~flag_q) == '0));
endmodule

// File: rtl/esb_regs.sv
module esb_regs
  import esb_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic                 rd_en_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [PORT_W-1:0]    wdata_i,
  input  logic [NUM_CH-1:0]    lvl_i,
  input  logic [NUM_CH-1:0]    flag_i,
  output logic [NUM_PORTS-1:0] port_we_o,
  output logic [POL_W-1:0]     pol_o,
  output logic [NUM_PORTS-1:0] mask_o,
  output logic                 ie_o,
  output logic [PORT_W-1:0]    rdata_o
);
  bank_e                bank_q;
  logic [NUM_PORTS-1:0] mask_q;
  logic [POL_W-1:0]     pol_q;
  logic                 ie_q;
  logic [PORT_W-1:0]    rdata_q, rd_mux;
  logic                 is_port;
  int unsigned          pidx;

  assign is_port = (int'(addr_i) < NUM_PORTS);
  assign pidx    = is_port ? int'(addr_i) : 0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q <= BANK_LEVEL;
      mask_q <= '0;
      pol_q  <= '0;
      ie_q   <= 1'b0;
    end else if (wr_en_i) begin
      unique case (addr_i)
        ADDR_CTRL: begin
          bank_q <= bank_e'(wdata_i[7:6]);
          if (bank_q == BANK_EVENT) mask_q[NUM_PORTS-1:MASK_LO_W] <= wdata_i[MASK_HI_W-1:0];
          else                      mask_q[MASK_LO_W-1:0]         <= wdata_i[MASK_LO_W-1:0];
        end
        ADDR_POL_LO: pol_q[PORT_W-1:0]     <= wdata_i;
        ADDR_POL_HI: pol_q[POL_W-1:PORT_W] <= wdata_i;
        ADDR_IE:     ie_q                  <= wdata_i[0];
        default: ;
      endcase
    end
  end

  genvar gp;
  generate
    for (gp = 0; gp < NUM_PORTS; gp++) begin : g_we
      assign port_we_o[gp] = wr_en_i && (addr_i == ADDR_W'(gp))
                             && (bank_q == BANK_EVENT) && !mask_q[gp];
    end
  endgenerate

  always_comb begin
    rd_mux = '0;
    if (is_port) begin
      case (bank_q)
        BANK_LEVEL: rd_mux = lvl_i[pidx*PORT_W +: PORT_W];
        BANK_EVENT: rd_mux = flag_i[pidx*PORT_W +: PORT_W];
        default:    rd_mux = '0;
      endcase
    end else if (addr_i == ADDR_CTRL) begin
      rd_mux[7:6] = bank_q;
      if (bank_q == BANK_EVENT) rd_mux[MASK_HI_W-1:0] = mask_q[NUM_PORTS-1:MASK_LO_W];
      else                      rd_mux[MASK_LO_W-1:0] = mask_q[MASK_LO_W-1:0];
    end else if (addr_i == ADDR_IE) begin
      rd_mux[0] = ie_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
  end

  assign pol_o   = pol_q;
  assign mask_o  = mask_q;
  assign ie_o    = ie_q;
  assign rdata_o = rdata_q;

  p_bank_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_CTRL) |=> (bank_q == $past(wdata_i[7:6])));

  p_pol_hidden_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && (addr_i == ADDR_POL_LO || addr_i == ADDR_POL_HI)) |=> (rdata_o == '0));

  p_bank0_no_we_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_q == BANK_LEVEL) |-> (port_we_o == '0));
endmodule

// File: rtl/cos_event_bank.sv
module cos_event_bank
  import esb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PORT_W-1:0] wdata_i,
  output logic [PORT_W-1:0] rdata_o,
  input  logic [NUM_CH-1:0] din_i,
  output logic              irq_no
);
  logic [NUM_CH-1:0]    lvl, flags;
  logic [NUM_PORTS-1:0] port_we, mask;
  logic [POL_W-1:0]     pol;
  logic                 ie;

  esb_sync #(.W(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (din_i),
    .q_o   (lvl)
  );

  esb_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .rd_en_i  (rd_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .lvl_i    (lvl),
    .flag_i   (flags),
    .port_we_o(port_we),
    .pol_o    (pol),
    .mask_o   (mask),
    .ie_o     (ie),
    .rdata_o  (rdata_o)
  );

  genvar gp;
  generate
    for (gp = 0; gp < NUM_PORTS; gp++) begin : g_port
      esb_port #(.W(PORT_W)) u_port (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .lvl_i  (lvl[gp*PORT_W +: PORT_W]),
        .pol_i  (pol[2*gp +: 2]),
        .we_i   (port_we[gp]),
        .wdata_i(wdata_i),
        .flag_o (flags[gp*PORT_W +: PORT_W])
      );

      p_masked_no_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == ADDR_W'(gp) && mask[gp])
        |=> (($past(flags[gp*PORT_W +: PORT_W]) & ~flags[gp*PORT_W +: PORT_W]) == '0));
    end
  endgenerate

  assign irq_no = ~(ie & (|flags));

  p_irq_off_when_disabled_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ie |-> irq_no);

  p_irq_quiet_no_flags_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags == '0) |-> irq_no);
endmodule

// File: tb/cos_event_bank_tb_top.sv
`timescale 1ns/1ps
module cos_event_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [63:0] din = '0;
  logic        irq_n;
  logic        rd_q = 1'b0;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  cos_event_bank dut_i (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .wr_en_i(wr_en),
    .rd_en_i(rd_en),
    .addr_i (addr),
    .wdata_i(wdata),
    .rdata_o(rdata),
    .din_i  (din),
    .irq_no (irq_n)
  );

  always @(posedge clk) rd_q <= rd_en;

  // monitor: compare registered read data against scoreboard
  always @(negedge clk) begin
    if (rd_q) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected read data %02h", rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          errors++;
          $display("FAIL %s got %02h exp %02h", t, rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic set_port(input int p, input logic [7:0] v);
    @(negedge clk);
    din[p*8 +: 8] = v;
    settle();
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    checks++;
    if (irq_n !== e) begin
      errors++;
      $display("FAIL %s irq_no got %0b exp %0b", t, irq_n, e);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk_irq(1'b1, "R1 irq high after reset");
    rd(4'hA, 8'h00, "R1 ctrl after reset");
    rd(4'hC, 8'h00, "R1 ie after reset");
    rd(4'h0, 8'h00, "R3 level port0 idle");

    // R3 live levels through synchronizer
    set_port(0, 8'hA5);
    set_port(3, 8'h3C);
    rd(4'h0, 8'hA5, "R3 level port0");
    rd(4'h3, 8'h3C, "R3 level port3");

    // R2 bank select
    wr(4'hA, 8'h40);
    rd(4'hA, 8'h40, "R2 bank1 readback");
    rd(4'h0, 8'h00, "R4/R8 flags stay clear while unarmed");

    // R5/R6 polarity
    wr(4'h8, 8'h02);
    rd(4'h8, 8'h00, "R6 polarity lo write-only");
    rd(4'h9, 8'h00, "R6 polarity hi write-only");

    // R7/R5 arm and sense
    wr(4'h0, 8'hFF);
    set_port(0, 8'h5A);
    rd(4'h0, 8'hAA, "R5 rising low nibble falling high nibble");
    chk_irq(1'b1, "R10 irq gated by enable");
    wr(4'hC, 8'h01);
    rd(4'hC, 8'h01, "R10 ie readback");
    chk_irq(1'b0, "R10 irq asserted");

    // R7 clear disarms
    wr(4'h0, 8'h00);
    rd(4'h0, 8'h00, "R7 clear flags");
    chk_irq(1'b1, "R10 irq released after clear");
    set_port(0, 8'hA5);
    rd(4'h0, 8'h00, "R7 disarmed after clear");

    // R8 rewrite 1 keeps flag; partial clear
    wr(4'h0, 8'h0F);
    set_port(0, 8'h5A);
    rd(4'h0, 8'h0A, "R8 armed low nibble only");
    wr(4'h0, 8'h0F);
    rd(4'h0, 8'h0A, "R8 writing 1 keeps flag");
    wr(4'h0, 8'h0D);
    rd(4'h0, 8'h08, "R7 partial clear");
    wr(4'h0, 8'h00);

    // R9 write mask
    wr(4'hA, 8'h00);
    wr(4'hA, 8'h01);
    rd(4'hA, 8'h01, "R9 bank0 mask port0");
    wr(4'hA, 8'h41);
    rd(4'hA, 8'h40, "R9 bank1 mask field");
    wr(4'h0, 8'hFF);
    set_port(0, 8'hA5);
    rd(4'h0, 8'h00, "R9 masked port ignores arm");
    wr(4'hA, 8'h42);
    rd(4'hA, 8'h42, "R9 port7 masked in bank1");
    wr(4'h7, 8'hFF);
    wr(4'h6, 8'hFF);
    set_port(6, 8'h0F);
    set_port(7, 8'hFF);
    rd(4'h6, 8'h0F, "R9 port6 unmasked senses");
    rd(4'h7, 8'h00, "R9 port7 masked stays clear");
    chk_irq(1'b0, "R10 irq from port6");
    wr(4'h6, 8'h00);
    chk_irq(1'b1, "R10 irq released port6");

    // R12 change of state: ch8 rising, ch12 falling on one signal
    wr(4'h8, 8'h0A);
    wr(4'h1, 8'h11);
    set_port(1, 8'h11);
    rd(4'h1, 8'h01, "R12 rise seen by rising channel");
    chk_irq(1'b0, "R12 irq on rise");
    wr(4'h1, 8'h00);
    wr(4'h1, 8'h11);
    set_port(1, 8'h00);
    rd(4'h1, 8'h10, "R12 fall seen by falling channel");
    chk_irq(1'b0, "R12 irq on fall");

    // R11 bank0 port writes ignored
    wr(4'hA, 8'h00);
    rd(4'h1, 8'h00, "R3 level port1 low in bank0");
    wr(4'h1, 8'h00);
    wr(4'hA, 8'h40);
    rd(4'h1, 8'h10, "R11 bank0 write did not clear");
    chk_irq(1'b0, "R11 irq still asserted");

    // R2 reserved bank reads 0
    wr(4'hA, 8'h80);
    rd(4'h1, 8'h00, "R2 reserved bank port read");
    rd(4'hA, 8'h80, "R2 reserved bank readback");

    while (exp_q.size() != 0) @(negedge clk);
    finish_run();
  end
endmodule